// File: doc/BRIEF.md
# CPU Memory Map Unit with Flash Wait States

This block sits on the bus of an 8-bit processor that has a 16-bit address space. Each cycle it looks at the address, picks one of three targets and steers the read data back to the processor's data-in lines. The targets are a 1 KB on-chip SRAM at the bottom of the map and a 1 KB I/O port window at 0x8000. Every other address falls through to an external flash device, which holds a flat 64 KB image. The two fast windows cover that image, so the 2 KB of flash underneath them can never be read.

The SRAM and the I/O window answer within the same cycle. A flash read is slower than a clock period, and the flash side runs asynchronously to the bus. For a flash read the unit latches the address and raises a request. It then waits for the synchronized acknowledge and for a minimum latency given in cycles. While this happens it keeps a synchronous hold output high, and the processor stays frozen on its current access. The processor clock is never touched. The processor therefore loses cycles only on flash reads and runs at full rate for everything else.

Top module: `memmap_stall_unit`

## Requirements
- R1: An access with address 0x0000–0x03FF asserts sram_cs in the same cycle with sram_addr equal to the low 10 address bits. A read returns sram_rdata on cpu_rdata in that cycle with cpu_hold low.
- R2: An access with address 0x8000–0x83FF asserts io_cs in the same cycle with io_addr equal to the low 10 address bits. A read returns io_rdata on cpu_rdata in that cycle with cpu_hold low.
- R3: A read of any other address (including 0x0400, 0x7FFF, 0x8400 and 0xFFFF) goes to flash, and flash_addr equals the full CPU address while flash_req is high.
- R4: The SRAM and I/O windows take priority over flash. An access in those windows never raises flash_req, and at most one of sram_cs, io_cs and flash_req is high at any time.
- R5: cpu_hold rises in the same cycle a flash read is presented. It stays high until the flash data is captured and falls in the cycle in which cpu_rdata first shows that data. With the default settings (FLASH_LAT=3, SYNC_STAGES=2), and flash_ack raised d cycles after flash_req, the hold lasts 1 + max(3, 3 + d) cycles.
- R6: flash_req rises on the clock edge after a flash read is accepted and stays high until the synchronized flash_ack is seen. A new request is not raised while the synchronized acknowledge from the previous one is still high, and cpu_hold stays high in that interval.
- R7: A write that decodes to flash is dropped. It raises no flash_req, no chip select and no cpu_hold.
- R8: A write to SRAM or I/O completes in one cycle. The chip select and its write enable are high in the same cycle, cpu_wdata is passed through and cpu_hold stays low.
- R9: While cpu_hold is high, changes on cpu_addr are ignored. flash_addr stays constant, no chip select rises, and the data returned is the data for the address originally latched.
- R10: After a synchronous active-low reset, cpu_hold, flash_req, sram_cs and io_cs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_en | input | 1 | A CPU access is present this cycle |
| cpu_we | input | 1 | Access is a write (1) or a read (0) |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Data to the CPU data-in lines |
| cpu_hold | output | 1 | Freeze request to the CPU |
| sram_cs | output | 1 | SRAM select |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 10 | SRAM word address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, valid in the select cycle |
| io_cs | output | 1 | I/O window select |
| io_we | output | 1 | I/O write enable |
| io_addr | output | 10 | I/O port offset |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data, valid in the select cycle |
| flash_req | output | 1 | Flash read request (four-phase) |
| flash_addr | output | 16 | Latched flash address |
| flash_rdata | input | 8 | Flash read data, valid while flash_ack is high |
| flash_ack | input | 1 | Flash acknowledge, asynchronous |

## Verification
The bench probes both edges of each window: 0x03FF against 0x0400, and 0x8000 and 0x83FF against 0x8400. A decoder off by one page would send one of these to the wrong target, or would raise a flash request under an overlay. Flash reads are timed at two acknowledge delays and must show the exact hold length. A sequencer that released early would put stale data on cpu_rdata, and one that released late would waste a cycle. One flash read moves the address into the SRAM window during the stall. An unlatched address or an ungated decode would then return the wrong byte or strobe the SRAM. A read straight after another flash read must not restart before the old acknowledge clears, and a flash write must leave request and hold untouched.

// File: rtl/memmap_pkg.sv
// Shared types for the memory map unit.
// Assumes: a single clock domain on the CPU side.
package memmap_pkg;

    // Target picked by the address decoder
    typedef enum logic [1:0] {
        RG_SRAM  = 2'd0,
        RG_IO    = 2'd1,
        RG_FLASH = 2'd2
    } region_e;

    // Flash sequencer phases
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_DONE = 2'd2
    } seq_e;

endpackage

// File: rtl/mm_decode.sv
// Address page decoder.
// Maps the upper address bits (the page number) to a target region.
// Page zero is the SRAM and IO_PAGE is the I/O window; every other page
// is flash. The SRAM test comes first, then I/O, and flash is the default.
// Assumes: IO_PAGE is not zero.
module mm_decode
    import memmap_pkg::*;
#(
    parameter int                PAGE_W  = 6,
    parameter logic [PAGE_W-1:0] IO_PAGE = 6'b100000
) (
    input  logic [PAGE_W-1:0] page,
    output region_e           region
);

    // Priority decode of the page number
    always_comb begin
        if (page == '0) begin
            region = RG_SRAM;
        end else if (page == IO_PAGE) begin
            region = RG_IO;
        end else begin
            region = RG_FLASH;
        end
    end

endmodule

// File: rtl/mm_sync.sv
// Level synchronizer for the flash acknowledge.
// Brings an asynchronous level into the clk domain through STAGES flops.
// Assumes: the input is a slow level from a four-phase handshake.
module mm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_chain
            // Shift the level through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mm_flash_seq.sv
// Flash read sequencer.
// On a flash read in the idle phase it latches the address and raises a
// four-phase request. It captures data once the synchronized acknowledge is
// high and at least FLASH_LAT cycles have been spent waiting. It then drops
// the request and spends one phase presenting the data before it goes idle
// again. A new request waits until the previous acknowledge has cleared.
// Assumes: ack_s is already synchronized to clk.
module mm_flash_seq
    import memmap_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int FLASH_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ack_s,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              st_idle,
    output logic              st_wait,
    output logic              st_done,
    output logic              req,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    localparam int              CNT_W    = $clog2(FLASH_LAT + 1);
    localparam logic [CNT_W-1:0] LAT_LAST = CNT_W'(FLASH_LAT - 1);

    seq_e             state;
    logic [CNT_W-1:0] wait_q;
    logic             lat_met;

    assign lat_met = (wait_q >= LAT_LAST);

    // Phase register, request level, address latch, data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            req    <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            wait_q <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (rd_go && !ack_s) begin
                        state  <= SQ_WAIT;
                        req    <= 1'b1;
                        addr_q <= addr_in;
                        wait_q <= '0;
                    end
                end
                SQ_WAIT: begin
                    if (ack_s && lat_met) begin
                        data_q <= rdata_in;
                        req    <= 1'b0;
                        state  <= SQ_DONE;
                    end else if (!lat_met) begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                SQ_DONE: begin
                    state <= SQ_IDLE;
                end
                default: begin
                    state <= SQ_IDLE;
                    req   <= 1'b0;
                end
            endcase
        end
    end

    // Phase flags for the top level
    always_comb begin
        st_idle = (state == SQ_IDLE);
        st_wait = (state == SQ_WAIT);
        st_done = (state == SQ_DONE);
    end

    // R6
    capture_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(ack_s));

    // R6
    no_restart_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> !$past(ack_s));

    // R5
    min_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(lat_met));

endmodule

// File: rtl/memmap_stall_unit.sv
// Memory map unit with flash wait states.
// Decodes each CPU access to SRAM, the I/O window or flash, drives the
// chip selects and muxes read data back to the CPU. A flash read holds the
// CPU through cpu_hold until the sequencer has captured the flash byte.
// The bus is decoded only while the sequencer is idle, so address changes
// during a stall have no effect.
// Assumes: the CPU keeps its access stable while cpu_hold is high, and
// samples cpu_rdata on the rising edge that ends a cycle with cpu_hold low.
module memmap_stall_unit
    import memmap_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter int                LOCAL_AW    = 10,
    parameter logic [ADDR_W-1:0] IO_BASE     = 16'h8000,
    parameter int                FLASH_LAT   = 3,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_en,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                cpu_hold,
    output logic                sram_cs,
    output logic                sram_we,
    output logic [LOCAL_AW-1:0] sram_addr,
    output logic [DATA_W-1:0]   sram_wdata,
    input  logic [DATA_W-1:0]   sram_rdata,
    output logic                io_cs,
    output logic                io_we,
    output logic [LOCAL_AW-1:0] io_addr,
    output logic [DATA_W-1:0]   io_wdata,
    input  logic [DATA_W-1:0]   io_rdata,
    output logic                flash_req,
    output logic [ADDR_W-1:0]   flash_addr,
    input  logic [DATA_W-1:0]   flash_rdata,
    input  logic                flash_ack
);

    localparam int                PAGE_W  = ADDR_W - LOCAL_AW;
    localparam logic [PAGE_W-1:0] IO_PAGE = IO_BASE[ADDR_W-1:LOCAL_AW];

    region_e           region;
    logic              fl_rd;
    logic              ack_sync;
    logic              st_idle;
    logic              st_wait;
    logic              st_done;
    logic [DATA_W-1:0] fl_data_q;

    mm_decode #(
        .PAGE_W  (PAGE_W),
        .IO_PAGE (IO_PAGE)
    ) decode_i (
        .page   (cpu_addr[ADDR_W-1:LOCAL_AW]),
        .region (region)
    );

    mm_sync #(
        .STAGES (SYNC_STAGES)
    ) ack_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (flash_ack),
        .q     (ack_sync)
    );

    mm_flash_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .FLASH_LAT (FLASH_LAT)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (fl_rd),
        .addr_in  (cpu_addr),
        .ack_s    (ack_sync),
        .rdata_in (flash_rdata),
        .st_idle  (st_idle),
        .st_wait  (st_wait),
        .st_done  (st_done),
        .req      (flash_req),
        .addr_q   (flash_addr),
        .data_q   (fl_data_q)
    );

    // Chip selects, gated so that only an idle bus is decoded
    always_comb begin
        sram_cs    = cpu_en && st_idle && (region == RG_SRAM);
        io_cs      = cpu_en && st_idle && (region == RG_IO);
        sram_we    = sram_cs && cpu_we;
        io_we      = io_cs && cpu_we;
        sram_addr  = cpu_addr[LOCAL_AW-1:0];
        io_addr    = cpu_addr[LOCAL_AW-1:0];
        sram_wdata = cpu_wdata;
        io_wdata   = cpu_wdata;
    end

    // Flash read detect and CPU hold (flash writes are dropped)
    always_comb begin
        fl_rd    = cpu_en && !cpu_we && (region == RG_FLASH);
        cpu_hold = (st_idle && fl_rd) || st_wait;
    end

    // Read data mux to the CPU data-in lines
    always_comb begin
        if (st_done) begin
            cpu_rdata = fl_data_q;
        end else begin
            case (region)
                RG_SRAM: cpu_rdata = sram_rdata;
                RG_IO:   cpu_rdata = io_rdata;
                default: cpu_rdata = fl_data_q;
            endcase
        end
    end

    // R5
    hold_covers_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_req |-> cpu_hold);

    // R5
    release_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_req) |-> !cpu_hold);

    // R4
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_cs, io_cs, flash_req}));

    // R1
    fast_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_cs || io_cs) |-> !cpu_hold);

    // R9
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && $past(flash_req)) |-> $stable(flash_addr));

    // R7
    req_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_req) |-> $past(cpu_en && !cpu_we));

endmodule

// File: tb/memmap_stall_unit_tb.sv
module memmap_stall_unit_tb_top;

    localparam int FLASH_LAT   = 3;
    localparam int SYNC_STAGES = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_en;
    logic        cpu_we;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic [7:0]  cpu_rdata;
    logic        cpu_hold;
    logic        sram_cs, sram_we;
    logic [9:0]  sram_addr;
    logic [7:0]  sram_wdata;
    logic [7:0]  sram_rdata;
    logic        io_cs, io_we;
    logic [9:0]  io_addr;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic        flash_req;
    logic [15:0] flash_addr;
    logic [7:0]  flash_rdata;
    logic        flash_ack;

    int total = 0;
    int bad   = 0;
    int ack_dly = 0;
    int fcnt;

    logic [7:0] sram_mem [1024];
    logic [9:0] io_last_addr;
    logic [7:0] io_last_data;

    always #5 clk = ~clk;

    memmap_stall_unit #(
        .FLASH_LAT   (FLASH_LAT),
        .SYNC_STAGES (SYNC_STAGES)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_hold(cpu_hold),
        .sram_cs(sram_cs), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .io_cs(io_cs), .io_we(io_we), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .flash_req(flash_req), .flash_addr(flash_addr),
        .flash_rdata(flash_rdata), .flash_ack(flash_ack)
    );

    function automatic logic [7:0] fdata(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // SRAM model: read data valid in the select cycle
    assign sram_rdata = sram_mem[sram_addr];
    always @(posedge clk) if (sram_cs && sram_we) sram_mem[sram_addr] <= sram_wdata;

    // I/O model
    assign io_rdata = io_addr[7:0] ^ 8'hC3;
    always @(posedge clk) if (io_cs && io_we) begin
        io_last_addr <= io_addr;
        io_last_data <= io_wdata;
    end

    // Flash model: ack raised ack_dly negedges after request, four-phase
    always @(negedge clk) begin
        if (!rst_n || !flash_req) begin
            flash_ack <= 1'b0;
            fcnt      <= 0;
            if (!rst_n) flash_rdata <= 8'h00;
        end else if (!flash_ack) begin
            if (fcnt >= ack_dly) begin
                flash_ack   <= 1'b1;
                flash_rdata <= fdata(flash_addr);
            end else begin
                fcnt <= fcnt + 1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic we, input logic [15:0] a, input logic [7:0] d);
        cpu_en = en; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    endtask

    // Advance to just after the next rising edge
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle_cycles(input int n);
        step(); drive(1'b0, 1'b0, 16'h0000, 8'h00);
        repeat (n) step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 16'h0000, 8'h00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10
        chk(!cpu_hold && !flash_req && !sram_cs && !io_cs, "R10 reset idle",
            {cpu_hold, flash_req, sram_cs, io_cs}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic sram_write(input logic [15:0] a, input logic [7:0] d);
        step(); drive(1'b1, 1'b1, a, d);
        @(negedge clk);
        // R8
        chk(sram_cs && sram_we && !cpu_hold && sram_wdata == d, "R8 sram write",
            {sram_cs, sram_we, cpu_hold}, 3'b110);
        // R1
        chk(sram_addr == a[9:0], "R1 sram addr", sram_addr, a[9:0]);
    endtask

    task automatic sram_read(input logic [15:0] a, input logic [7:0] exp);
        step(); drive(1'b1, 1'b0, a, 8'h00);
        @(negedge clk);
        // R1
        chk(sram_cs && !cpu_hold && cpu_rdata == exp, "R1 sram read",
            cpu_rdata, exp);
    endtask

    task automatic t_sram();
        sram_write(16'h0000, 8'h11);
        sram_write(16'h03FF, 8'h22);
        sram_write(16'h0155, 8'h33);
        sram_read(16'h0000, 8'h11);
        sram_read(16'h03FF, 8'h22);
        sram_read(16'h0155, 8'h33);
        idle_cycles(1);
    endtask

    task automatic t_io();
        step(); drive(1'b1, 1'b1, 16'h8000, 8'h44);
        @(negedge clk);
        // R8
        chk(io_cs && io_we && !cpu_hold && io_addr == 10'h000, "R8 io write",
            {io_cs, io_we, cpu_hold}, 3'b110);
        step(); drive(1'b1, 1'b0, 16'h83FF, 8'h00);
        @(negedge clk);
        // R8
        chk(io_last_data == 8'h44 && io_last_addr == 10'h000, "R8 io write landed",
            io_last_data, 8'h44);
        // R2
        chk(io_cs && !cpu_hold && io_addr == 10'h3FF && cpu_rdata == 8'h3C,
            "R2 io read top", cpu_rdata, 8'h3C);
        idle_cycles(1);
    endtask

    // R4: overlay addresses never start a flash request
    task automatic t_overlay(input logic [15:0] a);
        step(); drive(1'b1, 1'b0, a, 8'h00);
        @(negedge clk);
        chk(!cpu_hold && (sram_cs || io_cs), "R4 overlay decode", cpu_hold, 0);
        step(); drive(1'b0, 1'b0, 16'h0000, 8'h00);
        @(negedge clk);
        chk(!flash_req, "R4 no flash req under overlay", flash_req, 0);
    endtask

    task automatic t_flash_read(input logic [15:0] a, input int d, input logic move_addr);
        int n;
        int exp_n;
        logic done;
        exp_n = 1 + ((FLASH_LAT > SYNC_STAGES + 1 + d) ? FLASH_LAT : SYNC_STAGES + 1 + d);
        ack_dly = d;
        n = 0;
        done = 1'b0;
        step(); drive(1'b1, 1'b0, a, 8'h00);
        @(negedge clk);
        // R5
        chk(cpu_hold, "R5 hold in decode cycle", cpu_hold, 1);
        n = 1;
        for (int k = 0; k < 60 && !done; k++) begin
            step();
            if (move_addr) drive(1'b1, 1'b0, 16'h0010, 8'h00);
            @(negedge clk);
            if (cpu_hold) begin
                n++;
                if (flash_req) begin
                    // R3
                    chk(flash_addr == a, "R3 flash addr", flash_addr, a);
                end
                if (move_addr) begin
                    // R9
                    chk(!sram_cs && !io_cs, "R9 no select while held", sram_cs, 0);
                end
            end else begin
                done = 1'b1;
                // R5
                chk(cpu_rdata == fdata(a), "R5 flash data on release", cpu_rdata, fdata(a));
                // R5
                chk(n == exp_n, "R5 hold length", n, exp_n);
                if (move_addr) begin
                    // R9
                    chk(!sram_cs, "R9 no select on release", sram_cs, 0);
                end
            end
        end
        if (!done) chk(1'b0, "R5 hold never released", n, exp_n);
        idle_cycles(4);
    endtask

    task automatic t_flash_write();
        step(); drive(1'b1, 1'b1, 16'h9000, 8'hEE);
        @(negedge clk);
        // R7
        chk(!cpu_hold && !sram_cs && !io_cs, "R7 flash write no stall", cpu_hold, 0);
        step(); drive(1'b0, 1'b0, 16'h0000, 8'h00);
        @(negedge clk);
        // R7
        chk(!flash_req && !cpu_hold, "R7 flash write no request", flash_req, 0);
        idle_cycles(1);
    endtask

    task automatic wait_release(input logic [15:0] a, input string tag);
        logic done;
        done = 1'b0;
        for (int k = 0; k < 60 && !done; k++) begin
            step();
            @(negedge clk);
            if (!cpu_hold) begin
                done = 1'b1;
                chk(cpu_rdata == fdata(a), tag, cpu_rdata, fdata(a));
            end
        end
        if (!done) chk(1'b0, tag, 0, 1);
    endtask

    task automatic t_back_to_back();
        ack_dly = 0;
        step(); drive(1'b1, 1'b0, 16'h1234, 8'h00);
        wait_release(16'h1234, "R6 first read data");
        step(); drive(1'b1, 1'b0, 16'hABCD, 8'h00);
        @(negedge clk);
        // R6
        chk(cpu_hold && !flash_req, "R6 wait for ack clear", {cpu_hold, flash_req}, 2'b10);
        wait_release(16'hABCD, "R6 second read data");
        idle_cycles(4);
    endtask

    initial begin
        t_reset();
        t_sram();
        t_io();
        t_overlay(16'h03FF);
        t_overlay(16'h8000);
        t_overlay(16'h83FF);
        t_flash_read(16'h0400, 0, 1'b0);
        t_flash_read(16'h7FFF, 5, 1'b0);
        t_flash_read(16'h8400, 0, 1'b0);
        t_flash_read(16'hFFFF, 2, 1'b0);
        t_flash_read(16'hC35A, 1, 1'b1);
        t_flash_write();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog (all) actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule